// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers interrupt requests from a small group of basic sources and from 64 peripheral lines. The basic group has eight bits, and bit 0 is the system timer. The peripheral lines are split into two 32-bit banks. Each source has its own enable bit. Software never writes an enable mask directly. It writes ones into a set register to turn sources on, and ones into a separate clear register to turn them off. Several agents can therefore change their own enables without a read-modify-write sequence.

The block has a 32-bit register interface with byte addresses. Reads are combinational and writes take effect on the clock edge. The block also produces a CPU interrupt line and a prioritized logical interrupt number with a valid flag. In the number space, 0 to 7 are the basic bits, 8 to 39 are bank-1 bits 0 to 31, and 40 to 71 are bank-2 bits 0 to 31. All sources are level inputs that are synchronous to the clock. The controller holds no pending state of its own.

Top module: `bic_top`

## Requirements
- R1: After reset every enable bit is 0, so `cpu_irq` and `irq_valid` are low, `irq_num` is 0, and every register reads 0, whatever the sources do.
- R2: A write to a set register enables each source whose data bit is 1. The set registers are basic at 0x18 (bits 7:0), bank 1 at 0x10 and bank 2 at 0x14. Data bits that are 0 leave their enables unchanged.
- R3: A write to a clear register disables each source whose data bit is 1. The clear registers are basic at 0x24, bank 1 at 0x1C and bank 2 at 0x20. Data bits that are 0 leave their enables unchanged.
- R4: A read of either the set register or the clear register of a group returns that group's current enable mask. For the basic group, bits 31:8 read as 0.
- R5: Bank-1 pending reads at 0x04 and bank-2 pending reads at 0x08. Each shows its raw source levels ANDed with the bank's enables. Bits 7:0 of the basic pending register at 0x00 show the basic sources ANDed with the basic enables.
- R6: Bit 8 of 0x00 is high when any enabled bank-1 line is high. Bit 9 is high when any enabled bank-2 line is high. Bits 31:10 of 0x00 read as 0.
- R7: An enabled, active timer (basic bit 0) makes `irq_num` equal 0, whatever else is pending.
- R8: When the timer is not pending, the lowest enabled active peripheral line wins. Bank-1 bit i gives number 8+i, and bank-2 bit i gives number 40+i.
- R9: When neither the timer nor any peripheral line is pending, the lowest enabled active basic bit among bits 1 to 7 wins, and its number equals its bit position.
- R10: `cpu_irq` and `irq_valid` are both high exactly when any enabled source is active. When neither is high, `irq_num` is 0.
- R11: Writes to the pending addresses (0x00, 0x04, 0x08) or to unmapped addresses change no enable. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| basic_src | input | 8 | Basic source levels; bit 0 is the timer |
| periph_src | input | 64 | Peripheral source levels; bits 31:0 form bank 1 and bits 63:32 form bank 2 |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe; one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | OR of all enabled, active sources |
| irq_valid | output | 1 | High when `irq_num` names a pending source |
| irq_num | output | 7 | Prioritized logical interrupt number |

## Verification
The only state the block holds is the enable masks. A wrong enable bit therefore shows at the ports in the same cycle that its source goes active or its register is read. It appears as a wrong pending bit, a wrong summary bit, or a wrong winner on `irq_num`. If that source stays idle and its register is never read, the wrong bit stays hidden. For this reason the bench drives random source patterns every cycle and reads random registers alongside its writes, so a corrupted enable is exposed within a few cycles. Priority faults, such as the timer losing to a peripheral line, a bank-2 line beating bank 1, or a basic bit beating a peripheral line, show as a wrong `irq_num` on the first cycle where both competitors are active.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int BASIC_W   = 8;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int NUM_SRC   = BASIC_W + NUM_BANKS * BANK_W;
  localparam int NUM_W     = $clog2(NUM_SRC);

  // Byte offsets of the register map
  localparam logic [ADDR_W-1:0] OFS_BASIC_PEND = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_BANK_PEND  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BANK_SET   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_BASIC_SET  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_BANK_CLR   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_BASIC_CLR  = 6'h24;

  // Bit position of the first bank summary in the basic pending register
  localparam int SUMMARY_LSB = 8;
endpackage

// File: rtl/bic_en_reg.sv
module bic_en_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  logic [W-1:0] en_d;
  logic         upd;

  always_comb begin
    upd  = set_we | clr_we;
    en_d = en;
    if (set_we) en_d = en | wdata;
    if (clr_we) en_d = en & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en <= '0;
    else if (upd) en <= en_d;
  end
endmodule

// File: rtl/bic_first_one.sv
module bic_first_one #(
  parameter int W = 64,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bic_top.sv
module bic_top
  import bic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASIC_W-1:0] basic_src,
  input  logic [NUM_BANKS*BANK_W-1:0] periph_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq,
  output logic              irq_valid,
  output logic [NUM_W-1:0]  irq_num
);
  localparam int PW  = NUM_BANKS * BANK_W;
  localparam int PIW = $clog2(PW);
  localparam int BIW = $clog2(BASIC_W);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  // Basic group enables
  logic [BASIC_W-1:0] en_basic;
  logic [BASIC_W-1:0] pend_basic;
  logic               basic_set_we, basic_clr_we;

  assign basic_set_we = bus_we && (bus_addr == OFS_BASIC_SET);
  assign basic_clr_we = bus_we && (bus_addr == OFS_BASIC_CLR);

  bic_en_reg #(.W(BASIC_W)) u_en_basic (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (basic_set_we),
    .clr_we (basic_clr_we),
    .wdata  (bus_wdata[BASIC_W-1:0]),
    .en     (en_basic)
  );
  assign pend_basic = basic_src & en_basic;

  // Peripheral banks
  logic [BANK_W-1:0]    bank_en   [NUM_BANKS];
  logic [BANK_W-1:0]    bank_pend [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_any;
  logic [PW-1:0]        pend_periph;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_we, clr_we;
    assign set_we = bus_we && (bus_addr == OFS_BANK_SET + ADDR_W'(4 * b));
    assign clr_we = bus_we && (bus_addr == OFS_BANK_CLR + ADDR_W'(4 * b));

    bic_en_reg #(.W(BANK_W)) u_en (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (bus_wdata[BANK_W-1:0]),
      .en     (bank_en[b])
    );
    assign bank_pend[b] = periph_src[b*BANK_W +: BANK_W] & bank_en[b];
    assign bank_any[b]  = |bank_pend[b];
    assign pend_periph[b*BANK_W +: BANK_W] = bank_pend[b];
  end

  // Register read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_BASIC_PEND) begin
      bus_rdata[BASIC_W-1:0] = pend_basic;
      bus_rdata[SUMMARY_LSB +: NUM_BANKS] = bank_any;
    end
    if (bus_addr == OFS_BASIC_SET || bus_addr == OFS_BASIC_CLR)
      bus_rdata[BASIC_W-1:0] = en_basic;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == OFS_BANK_PEND + ADDR_W'(4 * b))
        bus_rdata[BANK_W-1:0] = bank_pend[b];
      if (bus_addr == OFS_BANK_SET + ADDR_W'(4 * b) ||
          bus_addr == OFS_BANK_CLR + ADDR_W'(4 * b))
        bus_rdata[BANK_W-1:0] = bank_en[b];
    end
  end

  // Priority: timer, then peripheral lines, then remaining basic bits
  logic           periph_found, basic_found, timer_hit;
  logic [PIW-1:0] periph_idx;
  logic [BIW-1:0] basic_idx;

  bic_first_one #(.W(PW)) u_prio_periph (
    .req   (pend_periph),
    .found (periph_found),
    .idx   (periph_idx)
  );

  bic_first_one #(.W(BASIC_W)) u_prio_basic (
    .req   ({pend_basic[BASIC_W-1:1], 1'b0}),
    .found (basic_found),
    .idx   (basic_idx)
  );

  assign timer_hit = pend_basic[0];

  always_comb begin
    irq_valid = timer_hit | periph_found | basic_found;
    irq_num   = '0;
    if (timer_hit)         irq_num = '0;
    else if (periph_found) irq_num = NUM_W'(BASIC_W) + NUM_W'(periph_idx);
    else if (basic_found)  irq_num = NUM_W'(basic_idx);
  end

  assign cpu_irq = (|pend_basic) | (|bank_any);
endmodule

// File: rtl/bic_checker.sv
module bic_checker
  import bic_pkg::*;
(
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic [BASIC_W-1:0]          basic_src,
  input logic [NUM_BANKS*BANK_W-1:0] periph_src,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic                        cpu_irq,
  input logic                        irq_valid,
  input logic [NUM_W-1:0]            irq_num,
  input logic [BASIC_W-1:0]          en_basic,
  input logic [BANK_W-1:0]           en_bank0,
  input logic [BANK_W-1:0]           en_bank1
);
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (en_basic == '0 && en_bank0 == '0 && en_bank1 == '0));

  assert_set_bank1_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == 6'h10) |=> ((en_bank0 & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_bank1_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == 6'h1C) |=> ((en_bank0 & $past(bus_wdata)) == '0));

  assert_basic_readback_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 6'h24) |-> (bus_rdata == {24'b0, en_basic}));

  assert_summary_bank2_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 6'h00) |-> (bus_rdata[9] == |(periph_src[63:32] & en_bank1)));

  assert_timer_first_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (basic_src[0] && en_basic[0]) |-> (irq_valid && irq_num == '0));

  assert_bank2_winner_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_valid && irq_num >= 7'd40) |->
      (periph_src[32 + int'(irq_num) - 40] && en_bank1[int'(irq_num) - 40]));

  assert_valid_matches_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_irq == irq_valid);
endmodule

bind bic_top bic_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .basic_src  (basic_src),
  .periph_src (periph_src),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .cpu_irq    (cpu_irq),
  .irq_valid  (irq_valid),
  .irq_num    (irq_num),
  .en_basic   (en_basic),
  .en_bank0   (bank_en[0]),
  .en_bank1   (bank_en[1])
);

// File: tb/tb_bic_top.sv
module tb_bic_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  basic_src;
  logic [63:0] periph_src;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        cpu_irq, irq_valid;
  logic [6:0]  irq_num;

  bic_top dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  string req_tag = "R1";

  // Behavioural model of the enable state
  logic [7:0]  m_enb;
  logic [31:0] m_en1, m_en2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_enb <= 8'h00; m_en1 <= 32'h0; m_en2 <= 32'h0;
    end else if (bus_we) begin
      case (bus_addr)
        6'h10: m_en1 <= m_en1 | bus_wdata;
        6'h14: m_en2 <= m_en2 | bus_wdata;
        6'h18: m_enb <= m_enb | bus_wdata[7:0];
        6'h1C: m_en1 <= m_en1 & ~bus_wdata;
        6'h20: m_en2 <= m_en2 & ~bus_wdata;
        6'h24: m_enb <= m_enb & ~bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] p1, p2;
    p1 = periph_src[31:0] & m_en1;
    p2 = periph_src[63:32] & m_en2;
    case (bus_addr)
      6'h00: return {22'b0, (p2 != 0), (p1 != 0), basic_src & m_enb};
      6'h04: return p1;
      6'h08: return p2;
      6'h10, 6'h1C: return m_en1;
      6'h14, 6'h20: return m_en2;
      6'h18, 6'h24: return {24'b0, m_enb};
      default: return 32'h0;
    endcase
  endfunction

  function automatic int exp_num();
    logic [7:0]  pb;
    logic [63:0] pp;
    pb = basic_src & m_enb;
    pp = {periph_src[63:32] & m_en2, periph_src[31:0] & m_en1};
    if (pb[0]) return 0;
    for (int i = 0; i < 64; i++) if (pp[i]) return 8 + i;
    for (int i = 1; i < 8; i++) if (pb[i]) return i;
    return -1;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, half a period after the active edge
  always @(negedge clk) begin
    int en;
    en = exp_num();
    check("rdata", bus_rdata, exp_rdata());
    check("cpu_irq", {31'b0, cpu_irq}, {31'b0, en >= 0});
    check("irq_valid", {31'b0, irq_valid}, {31'b0, en >= 0});
    check("irq_num", {25'b0, irq_num}, (en >= 0) ? en : 0);
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(logic [5:0] a);
    @(posedge clk); #2;
    bus_addr = a;
    @(posedge clk); #2;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; basic_src = 8'hFF; periph_src = '1;
    bus_addr = 6'h00; bus_we = 1'b0; bus_wdata = 32'h0;
    // R1: reset state with all sources active
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    foreach (bus_addr[i]) ;
    for (int a = 0; a < 64; a += 4) rd(a[5:0]);

    // R2: set bits in every group, zero bits leave enables alone
    req_tag = "R2";
    wr(6'h10, 32'h0000_F000); rd(6'h10);
    wr(6'h10, 32'h0000_0000); rd(6'h10);
    wr(6'h14, 32'h8000_0001); rd(6'h14);
    wr(6'h18, 32'h0000_00F0); rd(6'h18);

    // R3: clear some of them
    req_tag = "R3";
    wr(6'h1C, 32'h0000_3000); rd(6'h1C);
    wr(6'h20, 32'h0000_0001); rd(6'h20);
    wr(6'h24, 32'h0000_0010); rd(6'h24);

    // R4, R5, R6: readback and pending with a mixed source pattern
    req_tag = "R5";
    @(posedge clk); #2 periph_src = 64'h8000_0000_0000_4000; basic_src = 8'h60;
    rd(6'h00); rd(6'h04); rd(6'h08); rd(6'h14);

    // R8 and R9: peripheral line beats basic bits, then basic bits alone
    req_tag = "R8";
    @(posedge clk); #2 periph_src = 64'h0;
    req_tag = "R9";
    rd(6'h00);

    // R7: timer outranks everything
    req_tag = "R7";
    wr(6'h18, 32'h0000_0001);
    @(posedge clk); #2 basic_src = 8'hFF; periph_src = '1;
    rd(6'h00);

    // R11: writes to pending and unmapped addresses, unmapped reads
    req_tag = "R11";
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h04, 32'hFFFF_FFFF); wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF); wr(6'h28, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h10); rd(6'h14); rd(6'h18); rd(6'h2C);

    // R10 and all others: random traffic
    req_tag = "R10";
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #2;
      basic_src  = 8'($urandom) & 8'($urandom);
      periph_src = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      bus_addr   = 6'(($urandom % 16) * 4);
      bus_we     = ($urandom % 3) == 0;
      bus_wdata  = $urandom;
    end
    @(posedge clk); #2 bus_we = 1'b0;

    // R1: reset again mid-run clears every enable
    req_tag = "R1";
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd(6'h10); rd(6'h14); rd(6'h18);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule